// File: doc/BRIEF.md
# Parallel Port Host Registers and Interrupt Logic

This block is the host-facing register file and interrupt generator of a PC-style bidirectional parallel port with an extended control register. Software reaches it through a byte-wide bus. It can write an output data byte, steer the data lines between driving and listening, choose the port mode, read live and latched pin status, and learn which interrupt line the port is strapped to. The acknowledge and error pins enter through a synchronizer. The FIFO empty and full flags come from FIFO logic outside the block and are taken as plain inputs.

The acknowledge interrupt behaves differently in each mode. In bidirectional mode the trailing (rising) edge of the active-low acknowledge pulse is caught in a latch, and a status read clears it. In every other mode the request simply follows the pin. The error pin and the FIFO service condition are two further request sources. The single interrupt output is a level, not a pulse. The bus read data is combinational from the address. A read strobe only adds side effects.

Top module: `pport_host_regs`

## Requirements
- R1: After reset the control byte and the stored extended-control bits are 0 (mode 000, every interrupt source disabled), `irq` is 0, `pd_oe` is 1 and status reads 0x4C while both pins idle high.
- R2: Offsets decode as data 0x000, status 0x001, control 0x002, configuration 0x401 and extended control 0x402. Reads elsewhere return 0 and writes elsewhere change nothing.
- R3: With control bit 5 set in any mode other than 000, `pd_oe` is 0 and a data read returns `pd_in`. Otherwise `pd_oe` is 1 and a data read returns the last byte written. `pd_out` always holds the last byte written.
- R4: Extended-control reads return the written bits 7:2, with bit 1 = `fifo_full` and bit 0 = `fifo_empty`. Written bits 1:0 have no effect, so writing 0x34 while only empty is set reads back 0x35.
- R5: Both pins pass through two flops. Status bit 6 is the synchronized acknowledge pin, bit 3 is the synchronized error pin, bit 2 is the interrupt bit, and all other status bits read 0.
- R6: In mode 001 with control bit 4 set, a rising edge on `ack_n_pin` sets a latch on the third clock edge after the pin changes, and a falling edge sets nothing. While the latch is set, status bit 2 reads 0 and `irq` is 1. Leaving mode 001 clears the latch.
- R7: A status read clears the acknowledge latch. If a new edge is detected on the same clock edge as the read, the latch stays set.
- R8: In modes other than 001 with control bit 4 set, the acknowledge request follows the synchronized pin (active while it is low). Status bit 2 reads the inverse of `irq`, and a status read has no effect.
- R9: With control bit 4 clear, the acknowledge pin affects neither `irq` nor status bit 2.
- R10: In modes 010 and 011 with extended bit 2 at 0, the service condition sets bit 2 and raises a FIFO request on the next edge. The condition is `fifo_empty` when control bit 5 is 0 and `fifo_full` when it is 1. Any extended-control write clears that request, and such a write wins over a service event on the same edge.
- R11: In mode 011 with extended bit 4 set, either transition of the synchronized error pin raises a request on `irq`. An extended-control write with bit 4 at 0 clears it. In other modes the pin is ignored.
- R12: In mode 111, configuration reads return {0, irq, code, 000}, where the code for line 7,9,10,11,14,15,5 is 1..7 and any other line gives 0. Outside mode 111 the configuration read returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe (side effects only) |
| bus_rdata | output | 8 | Read data, combinational from address |
| ack_n_pin | input | 1 | Acknowledge pin, active low |
| err_n_pin | input | 1 | Error pin, active low |
| pd_in | input | 8 | Sampled data lines |
| pd_out | output | 8 | Data byte to drive |
| pd_oe | output | 1 | 1 = port drives data lines |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_full | input | 1 | FIFO full flag |
| irq | output | 1 | Level interrupt request |

## Verification
Two pairs of events can land on the same clock edge. In the first, a status read coincides with acknowledge-edge detection. The bench sweeps the read across the first five edges after the pin rises and predicts each outcome from the three-edge synchronizer latency: the latch survives a read up to and including the third edge, and the read clears it from the fourth edge on. In the second, an extended-control write meets a standing FIFO service condition. The bench checks that right after the write the flag and request are clear, and that one edge later they are set again. Configuration codes are swept across every supported interrupt line through a row of parameterized instances.

// File: rtl/pport_pkg.sv
package pport_pkg;

    localparam int BYTE_W   = 8;
    localparam int OFS_DATA = 'h000;
    localparam int OFS_STAT = 'h001;
    localparam int OFS_CTRL = 'h002;
    localparam int OFS_CFG  = 'h401;
    localparam int OFS_EXT  = 'h402;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        PM_STD   = 3'b000,
        PM_BIDIR = 3'b001,
        PM_FIFO  = 3'b010,
        PM_ECP   = 3'b011,
        PM_EPP   = 3'b100,
        PM_RSV   = 3'b101,
        PM_TEST  = 3'b110,
        PM_CFG   = 3'b111
    } port_mode_e;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_DATA, SEL_STAT, SEL_CTRL, SEL_CFG, SEL_EXT
    } reg_sel_e;

    // stored (writable) part of the extended control byte, bits 7:2
    typedef struct packed {
        port_mode_e mode;
        logic       err_ie;
        logic       spare;
        logic       svc_flag;
    } ext_field_t;

    typedef struct packed {
        logic [1:0] upper;
        logic       dir_in;
        logic       ack_ie;
        logic [3:0] lower;
    } ctrl_t;

    function automatic logic [2:0] irq_line_code(input int line);
        case (line)
            7:       return 3'd1;
            9:       return 3'd2;
            10:      return 3'd3;
            11:      return 3'd4;
            14:      return 3'd5;
            15:      return 3'd6;
            5:       return 3'd7;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic fifo_mode(input port_mode_e m);
        return (m == PM_FIFO) || (m == PM_ECP);
    endfunction

endpackage

// File: rtl/pport_pin_sync.sv
module pport_pin_sync #(
    parameter int   WIDTH     = 2,
    parameter int   STAGES    = 2,
    parameter logic IDLE_LVL  = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= {WIDTH{IDLE_LVL}};
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= {WIDTH{IDLE_LVL}};
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/pport_cfg_regs.sv
module pport_cfg_regs
    import pport_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we_data,
    input  logic       we_ctrl,
    input  logic       we_ext,
    input  byte_t      wdata,
    input  logic       fifo_empty,
    input  logic       fifo_full,
    output byte_t      data_q,
    output ctrl_t      ctrl_q,
    output ext_field_t ext_q,
    output logic       fifo_req
);
    logic svc_event;

    always_comb begin
        svc_event = fifo_mode(ext_q.mode) && !ext_q.svc_flag &&
                    (ctrl_q.dir_in ? fifo_full : fifo_empty);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q   <= '0;
            ctrl_q   <= '0;
            ext_q    <= '0;
            fifo_req <= 1'b0;
        end else begin
            if (we_data) data_q <= wdata;
            if (we_ctrl) ctrl_q <= ctrl_t'(wdata);
            if (we_ext) begin
                ext_q    <= ext_field_t'(wdata[BYTE_W-1:2]);
                fifo_req <= 1'b0;
            end else if (svc_event) begin
                ext_q.svc_flag <= 1'b1;
                fifo_req       <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pport_irq_unit.sv
module pport_irq_unit
    import pport_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  port_mode_e mode,
    input  logic       ack_ie,
    input  logic       err_ie,
    input  logic       ack_s,
    input  logic       err_s,
    input  logic       stat_rd,
    input  logic       ext_we,
    input  logic       ext_wr_err_ie,
    input  logic       fifo_req,
    output logic       ack_set,
    output logic       ack_lat,
    output logic       err_req,
    output logic       irq
);
    logic ack_d, err_d;
    logic in_bidir, ack_src, err_edge;

    always_comb begin
        in_bidir = (mode == PM_BIDIR);
        ack_set  = in_bidir && ack_ie && ack_s && !ack_d;
        err_edge = err_s ^ err_d;
        ack_src  = in_bidir ? ack_lat : (ack_ie && !ack_s);
        irq      = ack_src || err_req || fifo_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_d   <= 1'b1;
            err_d   <= 1'b1;
            ack_lat <= 1'b0;
            err_req <= 1'b0;
        end else begin
            ack_d <= ack_s;
            err_d <= err_s;
            if (!in_bidir)    ack_lat <= 1'b0;
            else if (ack_set) ack_lat <= 1'b1;
            else if (stat_rd) ack_lat <= 1'b0;
            if (ext_we && !ext_wr_err_ie)
                err_req <= 1'b0;
            else if ((mode == PM_ECP) && err_ie && err_edge)
                err_req <= 1'b1;
        end
    end
endmodule

// File: rtl/pport_host_regs.sv
module pport_host_regs
    import pport_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int SYNC_STAGES = 2,
    parameter int IRQ_LINE    = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    input  logic              ack_n_pin,
    input  logic              err_n_pin,
    input  logic [7:0]        pd_in,
    output logic [7:0]        pd_out,
    output logic              pd_oe,
    input  logic              fifo_empty,
    input  logic              fifo_full,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_EXT  = ADDR_W'(OFS_EXT);
    localparam logic [2:0]        LINE_CODE = irq_line_code(IRQ_LINE);

    reg_sel_e   sel;
    byte_t      data_q;
    ctrl_t      ctrl_q;
    ext_field_t ext_q;
    port_mode_e mode;
    logic       fifo_req, ack_set, ack_lat, err_req;
    logic       ack_s, err_s, dir_in, stat_b2;
    logic [1:0] pins_s;

    always_comb begin
        if      (bus_addr == A_DATA) sel = SEL_DATA;
        else if (bus_addr == A_STAT) sel = SEL_STAT;
        else if (bus_addr == A_CTRL) sel = SEL_CTRL;
        else if (bus_addr == A_CFG)  sel = SEL_CFG;
        else if (bus_addr == A_EXT)  sel = SEL_EXT;
        else                         sel = SEL_NONE;
    end

    pport_pin_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({ack_n_pin, err_n_pin}),
        .dout (pins_s)
    );
    assign ack_s = pins_s[1];
    assign err_s = pins_s[0];

    pport_cfg_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .we_data    (bus_wr && sel == SEL_DATA),
        .we_ctrl    (bus_wr && sel == SEL_CTRL),
        .we_ext     (bus_wr && sel == SEL_EXT),
        .wdata      (bus_wdata),
        .fifo_empty (fifo_empty),
        .fifo_full  (fifo_full),
        .data_q     (data_q),
        .ctrl_q     (ctrl_q),
        .ext_q      (ext_q),
        .fifo_req   (fifo_req)
    );
    assign mode = ext_q.mode;

    pport_irq_unit u_irq (
        .clk           (clk),
        .rst           (rst),
        .mode          (mode),
        .ack_ie        (ctrl_q.ack_ie),
        .err_ie        (ext_q.err_ie),
        .ack_s         (ack_s),
        .err_s         (err_s),
        .stat_rd       (bus_rd && sel == SEL_STAT),
        .ext_we        (bus_wr && sel == SEL_EXT),
        .ext_wr_err_ie (bus_wdata[4]),
        .fifo_req      (fifo_req),
        .ack_set       (ack_set),
        .ack_lat       (ack_lat),
        .err_req       (err_req),
        .irq           (irq)
    );

    always_comb begin
        dir_in  = ctrl_q.dir_in && (mode != PM_STD);
        pd_oe   = !dir_in;
        pd_out  = data_q;
        stat_b2 = (mode == PM_BIDIR) ? !ack_lat : !irq;
        unique case (sel)
            SEL_DATA: bus_rdata = dir_in ? pd_in : data_q;
            SEL_STAT: bus_rdata = {1'b0, ack_s, 2'b00, err_s, stat_b2, 2'b00};
            SEL_CTRL: bus_rdata = ctrl_q;
            SEL_CFG:  bus_rdata = (mode == PM_CFG) ? {1'b0, irq, LINE_CODE, 3'b000} : 8'h00;
            SEL_EXT:  bus_rdata = {ext_q, fifo_full, fifo_empty};
            default:  bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/pport_host_regs_chk.sv
module pport_host_regs_chk
    import pport_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic              bus_rd,
    input logic [7:0]        bus_rdata,
    input logic              fifo_empty,
    input logic              fifo_full,
    input logic              pd_oe,
    input port_mode_e        mode,
    input logic              ack_set,
    input logic              ack_lat,
    input logic              err_req,
    input logic              fifo_req
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_EXT  = ADDR_W'(OFS_EXT);

    assert_dir_turn_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_CTRL && bus_wdata[5] && mode != PM_STD) |=> !pd_oe);

    assert_ext_flags_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_EXT) |-> (bus_rdata[1:0] == {fifo_full, fifo_empty}));

    assert_latch_mode_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_lat) |-> ($past(mode) == PM_BIDIR));

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_STAT && !ack_set) |=> !ack_lat);

    assert_write_drops_fifo_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_EXT) |=> !fifo_req);

    assert_err_disable_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_EXT && !bus_wdata[4]) |=> !err_req);

    assert_cfg_hidden_R12: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_CFG && mode != PM_CFG) |-> (bus_rdata == 8'h00));
endmodule

bind pport_host_regs pport_host_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .pd_oe      (pd_oe),
    .mode       (mode),
    .ack_set    (ack_set),
    .ack_lat    (ack_lat),
    .err_req    (err_req),
    .fifo_req   (fifo_req)
);

// File: tb/pport_host_regs_bench.sv
module pport_host_regs_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NSW        = 8;
    localparam int LINES [NSW] = '{7, 9, 10, 11, 14, 15, 5, 4};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        ack_n = 1'b1;
    logic        err_n = 1'b1;
    logic [7:0]  pd_in = '0;
    logic [7:0]  pd_out;
    logic        pd_oe;
    logic        f_empty = 1'b0;
    logic        f_full = 1'b0;
    logic        irq;

    logic [7:0]  sw_rdata [NSW];
    logic [7:0]  sw_pdout [NSW];
    logic        sw_oe    [NSW];
    logic        sw_irq   [NSW];

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pport_host_regs u_pport_host_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .ack_n_pin(ack_n), .err_n_pin(err_n), .pd_in(pd_in), .pd_out(pd_out),
        .pd_oe(pd_oe), .fifo_empty(f_empty), .fifo_full(f_full), .irq(irq)
    );

    generate
        for (genvar g = 0; g < NSW; g++) begin : g_sweep
            pport_host_regs #(.IRQ_LINE(LINES[g])) u_sweep (
                .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
                .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(sw_rdata[g]),
                .ack_n_pin(ack_n), .err_n_pin(err_n), .pd_in(pd_in),
                .pd_out(sw_pdout[g]), .pd_oe(sw_oe[g]), .fifo_empty(f_empty),
                .fifo_full(f_full), .irq(sw_irq[g])
            );
        end
    endgenerate

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [10:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        idle(3);
        rst = 1'b0;

        // R1 reset state
        #1;
        chk("R1 irq", {7'b0, irq}, 8'h01 & 8'h00);
        chk("R1 pd_oe", {7'b0, pd_oe}, 8'h01);
        bus_read(11'h002, v); chk("R1 ctrl", v, 8'h00);
        bus_read(11'h402, v); chk("R1 ext", v, 8'h00);
        bus_read(11'h001, v); chk("R1 status", v, 8'h4C);

        // R2 decode holes
        bus_read(11'h003, v); chk("R2 hole 003", v, 8'h00);
        bus_read(11'h400, v); chk("R2 hole 400", v, 8'h00);
        bus_write(11'h003, 8'hFF);
        bus_write(11'h403, 8'hFF);
        bus_read(11'h002, v); chk("R2 stray write ctrl", v, 8'h00);
        bus_read(11'h402, v); chk("R2 stray write ext", v, 8'h00);

        // R3 data direction
        bus_write(11'h000, 8'h5A);
        chk("R3 pd_out", pd_out, 8'h5A);
        pd_in = 8'hC3;
        bus_write(11'h002, 8'h20);
        #1 chk("R3 std mode keeps drive", {7'b0, pd_oe}, 8'h01);
        bus_read(11'h000, v); chk("R3 std mode read latch", v, 8'h5A);
        bus_write(11'h402, 8'h20);
        #1 chk("R3 bidir input", {7'b0, pd_oe}, 8'h00);
        for (int k = 0; k < 256; k += 17) begin
            pd_in = 8'(k);
            bus_read(11'h000, v); chk("R3 pins read", v, 8'(k));
            chk("R3 pd_out held", pd_out, 8'h5A);
        end
        bus_write(11'h002, 8'h00);
        #1 chk("R3 drive again", {7'b0, pd_oe}, 8'h01);

        // R4 extended control read-only flags
        bus_write(11'h402, 8'h34);
        for (int f = 0; f < 4; f++) begin
            f_full = f[1]; f_empty = f[0];
            bus_read(11'h402, v); chk("R4 flags", v, 8'h34 | 8'(f));
        end
        f_full = 1'b0; f_empty = 1'b1;
        bus_read(11'h402, v); chk("R4 0x34 reads 0x35", v, 8'h35);
        f_empty = 1'b0;
        bus_write(11'h402, 8'h37);
        bus_read(11'h402, v); chk("R4 low bits ignored", v, 8'h34);

        // R5 synchronized pins, R9 ack disabled, R11 err ignored outside 011
        ack_n = 1'b0; err_n = 1'b0;
        idle(3);
        bus_read(11'h001, v); chk("R5 pins low", v, 8'h04);
        #1 chk("R11 err ignored in 001", {7'b0, irq}, 8'h00);
        ack_n = 1'b1; err_n = 1'b1;
        idle(4);
        bus_read(11'h001, v); chk("R9 no latch when disabled", v, 8'h4C);
        chk("R9 irq quiet", {7'b0, irq}, 8'h00);

        // R6 / R7 latch and read collision sweep
        bus_write(11'h402, 8'h20);
        bus_write(11'h002, 8'h10);
        ack_n = 1'b0;
        idle(4);
        bus_read(11'h001, v); chk("R6 leading edge ignored", v, 8'h0C);
        for (int e = 1; e <= 5; e++) begin
            ack_n = 1'b0;
            idle(4);
            @(negedge clk);
            ack_n = 1'b1;
            repeat (e - 1) @(negedge clk);
            bus_addr = 11'h001; bus_rd = 1'b1;
            #1 v = bus_rdata;
            @(negedge clk);
            bus_rd = 1'b0;
            chk("R6 bit2 seen by read", {7'b0, v[2]}, (e >= 4) ? 8'h00 : 8'h01);
            idle(4);
            #1 chk("R7 irq after collision", {7'b0, irq}, (e <= 3) ? 8'h01 : 8'h00);
            bus_read(11'h001, v);
            chk("R7 latch after collision", {7'b0, v[2]}, (e <= 3) ? 8'h00 : 8'h01);
            #1 chk("R7 read clears", {7'b0, irq}, 8'h00);
        end

        // R8 mirroring outside 001
        bus_write(11'h402, 8'h00);
        ack_n = 1'b0;
        idle(3);
        #1 chk("R8 irq follows pin", {7'b0, irq}, 8'h01);
        bus_read(11'h001, v); chk("R8 status", v, 8'h08);
        #1 chk("R8 read no effect", {7'b0, irq}, 8'h01);
        ack_n = 1'b1;
        idle(3);
        #1 chk("R8 pin released", {7'b0, irq}, 8'h00);
        bus_write(11'h002, 8'h00);
        ack_n = 1'b0;
        idle(3);
        #1 chk("R9 mirror disabled", {7'b0, irq}, 8'h00);
        bus_read(11'h001, v); chk("R9 status bit2", {7'b0, v[2]}, 8'h01);
        ack_n = 1'b1;
        idle(3);

        // R10 FIFO service
        f_empty = 1'b1; f_full = 1'b0;
        bus_write(11'h402, 8'h40);
        bus_read(11'h402, v); chk("R10 service sets flag", v, 8'h45);
        #1 chk("R10 irq", {7'b0, irq}, 8'h01);
        bus_write(11'h402, 8'h40);
        bus_addr = 11'h402;
        #1 chk("R10 write wins", bus_rdata, 8'h41);
        chk("R10 write clears irq", {7'b0, irq}, 8'h00);
        @(negedge clk);
        #1 chk("R10 re-arms next edge", {7'b0, irq}, 8'h01);
        f_empty = 1'b0;
        bus_write(11'h402, 8'h40);
        idle(2);
        bus_read(11'h402, v); chk("R10 no condition", v, 8'h40);
        #1 chk("R10 irq low", {7'b0, irq}, 8'h00);
        f_empty = 1'b1;
        bus_write(11'h402, 8'h20);
        idle(2);
        bus_read(11'h402, v); chk("R10 gated in 001", v, 8'h21);
        bus_write(11'h002, 8'h20);
        bus_write(11'h402, 8'h60);
        idle(2);
        bus_read(11'h402, v); chk("R10 input dir ignores empty", v, 8'h61);
        f_full = 1'b1; f_empty = 1'b0;
        idle(1);
        bus_read(11'h402, v); chk("R10 input dir uses full", v, 8'h66);
        #1 chk("R10 irq full", {7'b0, irq}, 8'h01);
        f_full = 1'b0;
        bus_write(11'h002, 8'h00);
        bus_write(11'h402, 8'h64);
        #1 chk("R10 masked", {7'b0, irq}, 8'h00);

        // R11 error pin
        bus_write(11'h402, 8'h74);
        err_n = 1'b0;
        idle(4);
        #1 chk("R11 err edge", {7'b0, irq}, 8'h01);
        err_n = 1'b1;
        idle(4);
        #1 chk("R11 held", {7'b0, irq}, 8'h01);
        bus_write(11'h402, 8'h64);
        #1 chk("R11 cleared", {7'b0, irq}, 8'h00);
        err_n = 1'b0;
        idle(4);
        #1 chk("R11 disabled", {7'b0, irq}, 8'h00);
        err_n = 1'b1;
        idle(4);

        // R12 configuration read
        bus_write(11'h402, 8'hE0);
        bus_addr = 11'h401;
        #1;
        chk("R12 code main", bus_rdata, 8'h18);
        for (int g = 0; g < NSW; g++)
            chk("R12 code sweep", sw_rdata[g], (g < 7) ? 8'((g + 1) << 3) : 8'h00);
        bus_write(11'h002, 8'h10);
        ack_n = 1'b0;
        idle(3);
        bus_read(11'h401, v); chk("R12 irq bit6", v, 8'h58);
        ack_n = 1'b1;
        idle(3);
        bus_write(11'h402, 8'h00);
        bus_read(11'h401, v); chk("R12 hidden", v, 8'h00);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule